// File: doc/BRIEF.md
# Power state controller

This block is the synchronous controller that decides the power state of a power-management device. It moves between five states: no supply, configuration, off, active and sleep. Its inputs are a supply-valid flag, a power button (active low), a hold pin, a sleep pin, a thermal-shutdown flag, a pending unmasked-interrupt flag and a set of register control bits. From the current state it drives a global reset, an active-low power-on reset, a regulator enable, a low-power request and a one-cycle pulse that loads register defaults. It also keeps a sticky long-press interrupt flag.

A power-on is requested by a pressed button, a high hold pin, a set hold bit, or a pending interrupt while its wake window is still open. The wake window gives the host a fixed number of cycles to take over by asserting hold. A power-off is requested when no power-on source remains, on thermal shutdown, on the device-off bit, or on a button held past the long-press limit. Sleep is the AND of the sleep pin at its programmed level, the sleep-enable bit and no pending interrupt. Both timers count clock cycles and restart as soon as their condition goes away.

Top module: `pwr_state_ctrl`

## Requirements
- R1: With rst_n low at a clock edge, or supply_ok low at a clock edge, the state becomes no-supply (code 0) after that edge. Loss of supply overrides every other state. In no-supply, glob_rst=1 and por_n, reg_en and lowpwr_req are 0.
- R2: From no-supply the state moves to configuration (code 1) on the first edge that sees supply_ok high. It stays there for exactly CFG_CYC cycles and then moves to off (code 2). dflt_load is 1 only during the first configuration cycle.
- R3: In off, reg_en=0 and por_n=0. Off moves to active (code 3) on an edge that sees a power-on source: pwr_btn_n low, hold_pin high, hold_bit high, or an open wake window. This move is blocked while therm_sd, dev_off_bit or the long-press condition holds.
- R4: A high irq_pend is a power-on source for its first WAKE_CYC cycles only. After that it stops counting as one until irq_pend goes low and rises again.
- R5: In active, por_n=1, reg_en=1 and lowpwr_req=0. Active is left for turn-off on an edge that sees no power-on source, or therm_sd high, or dev_off_bit high, or the long-press condition.
- R6: The long-press condition holds once pwr_btn_n has been low with lp_dis_bit low for LP_CYC consecutive edges, and lasts while the button stays low. With lp_dis_bit high the condition never forms.
- R7: lp_irq is set on every edge at which the long-press condition holds. Once set, it stays set until an edge that sees lp_irq_clr high with no long-press condition present.
- R8: Active moves to sleep (code 4) on an edge where no turn-off applies and all three of these hold: sleep_pin equals sleep_pol_bit (0 means the pin is active low), sleep_en_bit is 1, and irq_pend is 0.
- R9: In sleep, reg_en=1, por_n=1 and lowpwr_req=1. Sleep returns to active when any sleep term is false, and goes straight to turn-off on any turn-off condition of R5.
- R10: A turn-off from active or sleep goes to configuration instead of off when load_dflt_bit is 1. When PRESS_TO_CFG=1, a turn-off caused by a long press also goes to configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Battery supply high enough for the always-on regulator |
| pwr_btn_n | input | 1 | Power button, low when pressed |
| hold_pin | input | 1 | Hold pin from the host, high keeps power on |
| sleep_pin | input | 1 | Sleep request pin, level set by sleep_pol_bit |
| therm_sd | input | 1 | Die thermal-shutdown flag |
| irq_pend | input | 1 | An unmasked interrupt is pending |
| hold_bit | input | 1 | Register hold bit (reset value 0) |
| dev_off_bit | input | 1 | Register bit that requests turn-off |
| sleep_en_bit | input | 1 | Register bit that allows sleep |
| sleep_pol_bit | input | 1 | Active level of sleep_pin (0 = low) |
| lp_dis_bit | input | 1 | Disables the long-press shutdown |
| load_dflt_bit | input | 1 | Makes a turn-off go through configuration |
| lp_irq_clr | input | 1 | Clears the long-press interrupt flag |
| state_o | output | 3 | Current state code (0 no-supply, 1 config, 2 off, 3 active, 4 sleep) |
| glob_rst | output | 1 | Global reset, high in no-supply |
| por_n | output | 1 | Active-low power-on reset, released in active and sleep |
| reg_en | output | 1 | Regulator enable |
| lowpwr_req | output | 1 | Low-power request to the selected supplies |
| dflt_load | output | 1 | One-cycle pulse that loads register defaults |
| lp_irq | output | 1 | Sticky long-press interrupt flag |

## Verification
The bench builds the block with LP_CYC=5, WAKE_CYC=4, CFG_CYC=3 and PRESS_TO_CFG=1. With such short timers, every long-press duration from one cycle to one past the limit can be swept in a few hundred cycles. So can every cycle at which the host can acknowledge the wake window, and the cycle count of the configuration stay can be checked edge by edge. The small size also lets the bench go through all sixteen combinations of sleep pin, polarity, enable and pending interrupt. Setting PRESS_TO_CFG brings the long-press path into configuration within reach.

// File: rtl/pwr_state_pkg.sv
// Package: shared state encoding and output bundle for the power state
// controller. Assumes a 3-bit state code that is visible at the top ports.
package pwr_state_pkg;

    typedef enum logic [2:0] {
        PS_NOSUP = 3'd0,
        PS_CFG   = 3'd1,
        PS_OFF   = 3'd2,
        PS_ACT   = 3'd3,
        PS_SLP   = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic glob_rst;
        logic por_n;
        logic reg_en;
        logic lowpwr;
    } pwr_out_t;

endpackage

// File: rtl/pwr_run_counter.sv
// Module: saturating run-length counter. It counts the consecutive clock
// edges at which 'run' is high, stops at LIMIT and clears on any edge
// where 'run' is low. 'at_limit' is high while run holds and the count
// has reached LIMIT. Assumes LIMIT >= 2.
module pwr_run_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count consecutive run cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LIM_C) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Report the limit only while the qualifying condition is still present.
    always_comb at_limit = run && (cnt == LIM_C);

endmodule

// File: rtl/pwr_seq_fsm.sv
// Module: state sequencer. It takes the condition terms already combined
// by the top and steps through no-supply, configuration, off, active and
// sleep. The configuration stay is timed by an internal counter.
// Assumes CFG_CYC >= 1. Every condition input is sampled at the clock edge.
module pwr_seq_fsm
    import pwr_state_pkg::*;
#(
    parameter int CFG_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pon,        // any power-on source present
    input  logic       hard_off,   // thermal, device-off or long press
    input  logic       slp_ok,     // all sleep terms true
    input  logic       to_cfg,     // turn-off should pass through config
    output pwr_state_e state,
    output logic       cfg_first
);
    localparam int CCW = (CFG_CYC > 1) ? $clog2(CFG_CYC) : 1;
    localparam logic [CCW-1:0] CFG_LAST = CCW'(CFG_CYC - 1);

    pwr_state_e     nxt;
    logic [CCW-1:0] cfg_cnt;
    logic           off_req;
    pwr_state_e     off_tgt;

    // Turn-off request and where it leads.
    always_comb begin
        off_req = hard_off || !pon;
        off_tgt = to_cfg ? PS_CFG : PS_OFF;
    end

    // Next-state selection; loss of supply dominates every state.
    always_comb begin
        nxt = state;
        if (!supply_ok) begin
            nxt = PS_NOSUP;
        end else begin
            case (state)
                PS_NOSUP: nxt = PS_CFG;
                PS_CFG:   if (cfg_cnt == CFG_LAST) nxt = PS_OFF;
                PS_OFF:   if (pon && !hard_off) nxt = PS_ACT;
                PS_ACT: begin
                    if (off_req)     nxt = off_tgt;
                    else if (slp_ok) nxt = PS_SLP;
                end
                PS_SLP: begin
                    if (off_req)      nxt = off_tgt;
                    else if (!slp_ok) nxt = PS_ACT;
                end
                default:  nxt = PS_NOSUP;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_NOSUP;
        else        state <= nxt;
    end

    // Configuration dwell counter: cleared on entry, advanced while inside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_cnt <= '0;
        end else if (state != PS_CFG) begin
            cfg_cnt <= '0;
        end else if (cfg_cnt != CFG_LAST) begin
            cfg_cnt <= cfg_cnt + 1'b1;
        end
    end

    // First cycle of a configuration stay.
    always_comb cfg_first = (state == PS_CFG) && (cfg_cnt == '0);

endmodule

// File: rtl/pwr_out_decode.sv
// Module: Moore output decode. It maps the current state onto the reset,
// enable and low-power outputs. Assumes the state code is always legal;
// any other code is treated like no-supply.
module pwr_out_decode
    import pwr_state_pkg::*;
(
    input  pwr_state_e state,
    output pwr_out_t   outs
);
    // Per-state output levels.
    always_comb begin
        outs = '{glob_rst: 1'b0, por_n: 1'b0, reg_en: 1'b0, lowpwr: 1'b0};
        case (state)
            PS_NOSUP: outs.glob_rst = 1'b1;
            PS_CFG:   ;
            PS_OFF:   ;
            PS_ACT: begin
                outs.por_n  = 1'b1;
                outs.reg_en = 1'b1;
            end
            PS_SLP: begin
                outs.por_n  = 1'b1;
                outs.reg_en = 1'b1;
                outs.lowpwr = 1'b1;
            end
            default:  outs.glob_rst = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwr_state_ctrl.sv
// Module: top of the power state controller. It combines pins and register
// bits into power-on, power-off and sleep terms, runs the long-press and
// wake-window timers, sequences the state and drives the outputs.
// Assumes all inputs are synchronous to clk. Timer lengths are in cycles.
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int LP_CYC       = 20_000_000,
    parameter int WAKE_CYC     = 2_000_000,
    parameter int CFG_CYC      = 16,
    parameter bit PRESS_TO_CFG = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pwr_btn_n,
    input  logic       hold_pin,
    input  logic       sleep_pin,
    input  logic       therm_sd,
    input  logic       irq_pend,
    input  logic       hold_bit,
    input  logic       dev_off_bit,
    input  logic       sleep_en_bit,
    input  logic       sleep_pol_bit,
    input  logic       lp_dis_bit,
    input  logic       load_dflt_bit,
    input  logic       lp_irq_clr,
    output logic [2:0] state_o,
    output logic       glob_rst,
    output logic       por_n,
    output logic       reg_en,
    output logic       lowpwr_req,
    output logic       dflt_load,
    output logic       lp_irq
);
    logic       press_run;
    logic       lp_long;
    logic       wake_spent;
    logic       wake_on;
    logic       pon;
    logic       hard_off;
    logic       slp_ok;
    logic       to_cfg;
    logic       cfg_first;
    logic       lp_flag;
    pwr_state_e state;
    pwr_out_t   outs;

    // Press timing runs only while the button is down and the feature is on.
    always_comb press_run = !pwr_btn_n && !lp_dis_bit;

    pwr_run_counter #(.LIMIT(LP_CYC)) i_press_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (press_run),
        .at_limit (lp_long)
    );

    pwr_run_counter #(.LIMIT(WAKE_CYC)) i_wake_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (irq_pend),
        .at_limit (wake_spent)
    );

    // Combine the pin and register terms into the sequencer's conditions.
    always_comb begin
        wake_on  = irq_pend && !wake_spent;
        pon      = !pwr_btn_n || hold_pin || hold_bit || wake_on;
        hard_off = therm_sd || dev_off_bit || lp_long;
        slp_ok   = (sleep_pin == sleep_pol_bit) && sleep_en_bit && !irq_pend;
    end

    // Turn-off destination; the parameter picks whether a long press forces config.
    generate
        if (PRESS_TO_CFG) begin : g_press_cfg
            always_comb to_cfg = load_dflt_bit || lp_long;
        end else begin : g_press_off
            always_comb to_cfg = load_dflt_bit;
        end
    endgenerate

    pwr_seq_fsm #(.CFG_CYC(CFG_CYC)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pon       (pon),
        .hard_off  (hard_off),
        .slp_ok    (slp_ok),
        .to_cfg    (to_cfg),
        .state     (state),
        .cfg_first (cfg_first)
    );

    pwr_out_decode i_dec (
        .state (state),
        .outs  (outs)
    );

    // Sticky long-press flag: setting wins over a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)          lp_flag <= 1'b0;
        else if (lp_long)    lp_flag <= 1'b1;
        else if (lp_irq_clr) lp_flag <= 1'b0;
    end

    // Drive the ports.
    always_comb begin
        state_o    = state;
        glob_rst   = outs.glob_rst;
        por_n      = outs.por_n;
        reg_en     = outs.reg_en;
        lowpwr_req = outs.lowpwr;
        dflt_load  = cfg_first;
        lp_irq     = lp_flag;
    end

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
// Module: assertion checker for pwr_state_ctrl. It sees the top's ports
// only and is attached by the bind below.
module pwr_state_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       pwr_btn_n,
    input logic       hold_bit,
    input logic       therm_sd,
    input logic       dev_off_bit,
    input logic       sleep_en_bit,
    input logic       load_dflt_bit,
    input logic       lp_irq_clr,
    input logic [2:0] state_o,
    input logic       glob_rst,
    input logic       por_n,
    input logic       reg_en,
    input logic       lowpwr_req,
    input logic       dflt_load,
    input logic       lp_irq
);
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    assert_nosup_outs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> (glob_rst && !por_n && !reg_en && !lowpwr_req));

    assert_brownout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_o == 3'd0));

    assert_cfg_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && supply_ok) |=> (state_o == 3'd1 && dflt_load));

    assert_load_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_load |=> !dflt_load);

    assert_off_outs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |-> (!reg_en && !por_n && !glob_rst));

    assert_hold_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && supply_ok && hold_bit && pwr_btn_n && !therm_sd && !dev_off_bit)
        |=> (state_o == 3'd3));

    assert_act_outs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |-> (reg_en && por_n && !lowpwr_req));

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_irq && !lp_irq_clr) |=> lp_irq);

    assert_sleep_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && !sleep_en_bit) |=> (state_o != 3'd4));

    assert_slp_outs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> (reg_en && por_n && lowpwr_req));

    assert_dflt_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && supply_ok && load_dflt_bit && therm_sd) |=> (state_o == 3'd1));

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .pwr_btn_n     (pwr_btn_n),
    .hold_bit      (hold_bit),
    .therm_sd      (therm_sd),
    .dev_off_bit   (dev_off_bit),
    .sleep_en_bit  (sleep_en_bit),
    .load_dflt_bit (load_dflt_bit),
    .lp_irq_clr    (lp_irq_clr),
    .state_o       (state_o),
    .glob_rst      (glob_rst),
    .por_n         (por_n),
    .reg_en        (reg_en),
    .lowpwr_req    (lowpwr_req),
    .dflt_load     (dflt_load),
    .lp_irq        (lp_irq)
);

// File: tb/test_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_pwr_state_ctrl;
    localparam int LP   = 5;
    localparam int WK   = 4;
    localparam int CFGN = 3;
    localparam logic [2:0] S_NOSUP = 3'd0, S_CFG = 3'd1, S_OFF = 3'd2,
                           S_ACT = 3'd3, S_SLP = 3'd4;

    logic clk = 1'b0;
    logic rst_n, supply_ok, pwr_btn_n, hold_pin, sleep_pin, therm_sd, irq_pend;
    logic hold_bit, dev_off_bit, sleep_en_bit, sleep_pol_bit, lp_dis_bit;
    logic load_dflt_bit, lp_irq_clr;
    logic [2:0] state_o;
    logic glob_rst, por_n, reg_en, lowpwr_req, dflt_load, lp_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwr_state_ctrl #(
        .LP_CYC(LP), .WAKE_CYC(WK), .CFG_CYC(CFGN), .PRESS_TO_CFG(1'b1)
    ) i_pwr_state_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwr_btn_n(pwr_btn_n),
        .hold_pin(hold_pin), .sleep_pin(sleep_pin), .therm_sd(therm_sd),
        .irq_pend(irq_pend), .hold_bit(hold_bit), .dev_off_bit(dev_off_bit),
        .sleep_en_bit(sleep_en_bit), .sleep_pol_bit(sleep_pol_bit),
        .lp_dis_bit(lp_dis_bit), .load_dflt_bit(load_dflt_bit),
        .lp_irq_clr(lp_irq_clr), .state_o(state_o), .glob_rst(glob_rst),
        .por_n(por_n), .reg_en(reg_en), .lowpwr_req(lowpwr_req),
        .dflt_load(dflt_load), .lp_irq(lp_irq)
    );

    // Advance one edge, then settle 1 ns past it before driving or sampling.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected outputs for each state, checked together.
    task automatic chk_state(input string req, input logic [2:0] exp);
        chk(req, state_o, exp);
        chk(req, glob_rst, exp == S_NOSUP);
        chk(req, por_n, exp == S_ACT || exp == S_SLP);
        chk(req, reg_en, exp == S_ACT || exp == S_SLP);
        chk(req, lowpwr_req, exp == S_SLP);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; supply_ok = 0; pwr_btn_n = 1; hold_pin = 0; sleep_pin = 1;
        therm_sd = 0; irq_pend = 0; hold_bit = 0; dev_off_bit = 0;
        sleep_en_bit = 0; sleep_pol_bit = 0; lp_dis_bit = 0;
        load_dflt_bit = 0; lp_irq_clr = 0;
        tick(); tick();
        chk_state("R1 reset", S_NOSUP);
        chk("R7 reset flag", lp_irq, 0);
        rst_n = 1; tick();
        chk_state("R1 no supply", S_NOSUP);

        // R2: configuration dwell and load pulse
        supply_ok = 1;
        for (int k = 1; k <= CFGN; k++) begin
            tick();
            chk_state("R2 config dwell", S_CFG);
            chk("R2 load pulse", dflt_load, k == 1);
        end
        tick();
        chk_state("R2 to off", S_OFF);
        tick();
        chk_state("R3 idle off", S_OFF);

        // R3/R5: each power-on source turns on, its removal turns off
        for (int s = 0; s < 3; s++) begin
            pwr_btn_n = (s != 0); hold_pin = (s == 1); hold_bit = (s == 2);
            tick();
            chk_state("R3 source on", S_ACT);
            pwr_btn_n = 1; hold_pin = 0; hold_bit = 0;
            tick();
            chk_state("R5 source gone", S_OFF);
        end

        // R3: power-on blocked by thermal and device-off; R5 turn-off causes
        hold_bit = 1; therm_sd = 1; tick();
        chk_state("R3 thermal blocks", S_OFF);
        therm_sd = 0; tick();
        chk_state("R3 hold on", S_ACT);
        therm_sd = 1; tick();
        chk_state("R5 thermal off", S_OFF);
        therm_sd = 0; tick();
        dev_off_bit = 1; tick();
        chk_state("R5 dev off", S_OFF);
        tick();
        chk_state("R3 dev off blocks", S_OFF);
        dev_off_bit = 0; tick();
        chk_state("R3 back on", S_ACT);

        // R6/R7/R10: sweep press length; long press goes via config
        for (int d = 1; d <= LP + 1; d++) begin
            pwr_btn_n = 0;
            repeat (d) tick();
            chk("R6 press state", state_o, (d <= LP) ? S_ACT : S_CFG);
            chk("R7 flag set", lp_irq, d >= LP + 1);
            pwr_btn_n = 1; tick();
            chk("R7 flag sticky", lp_irq, d >= LP + 1);
            lp_irq_clr = 1; tick(); lp_irq_clr = 0;
            chk("R7 flag cleared", lp_irq, 0);
            repeat (8) tick();
            chk_state("R10 recovers", S_ACT);
        end
        // R7: clear ignored while the press is held past the limit
        pwr_btn_n = 0; lp_irq_clr = 1;
        repeat (LP + 1) tick();
        chk("R7 clear loses to set", lp_irq, 1);
        pwr_btn_n = 1; tick(); lp_irq_clr = 0;
        chk("R7 clear after release", lp_irq, 0);
        repeat (8) tick();
        // R6: disabled long press
        lp_dis_bit = 1; pwr_btn_n = 0;
        repeat (LP + 3) tick();
        chk_state("R6 disabled stays", S_ACT);
        chk("R6 disabled no flag", lp_irq, 0);
        pwr_btn_n = 1; lp_dis_bit = 0; tick();

        // R8/R9: every combination of sleep terms
        for (int i = 0; i < 16; i++) begin
            sleep_pin = i[0]; sleep_pol_bit = i[1]; sleep_en_bit = i[2]; irq_pend = i[3];
            tick();
            chk_state("R8 sleep decode",
                (i[0] == i[1] && i[2] && !i[3]) ? S_SLP : S_ACT);
            sleep_en_bit = 0; irq_pend = 0; tick();
            chk_state("R9 sleep exit", S_ACT);
        end
        sleep_pin = 0; sleep_pol_bit = 0; sleep_en_bit = 1; tick();
        chk_state("R8 low level sleep", S_SLP);
        therm_sd = 1; tick();
        chk_state("R9 sleep to off", S_OFF);
        therm_sd = 0; sleep_en_bit = 0; sleep_pin = 1; tick();
        chk_state("R9 on again", S_ACT);

        // R10: load-defaults bit routes turn-off through config
        load_dflt_bit = 1; dev_off_bit = 1; tick();
        chk_state("R10 to config", S_CFG);
        chk("R10 load pulse", dflt_load, 1);
        load_dflt_bit = 0; dev_off_bit = 0;
        repeat (5) tick();
        chk_state("R10 back active", S_ACT);

        // R4: wake window, acknowledged after a cycles or never
        hold_bit = 0; tick();
        chk_state("R4 start off", S_OFF);
        for (int a = 1; a <= WK + 1; a++) begin
            irq_pend = 1;
            for (int k = 1; k <= a; k++) begin
                tick();
                chk("R4 window", state_o, (k <= WK) ? S_ACT : S_OFF);
            end
            if (a <= WK) hold_bit = 1;
            repeat (WK + 2) tick();
            chk("R4 after window", state_o, (a <= WK) ? S_ACT : S_OFF);
            irq_pend = 0; hold_bit = 0; tick();
            chk_state("R4 cleanup", S_OFF);
        end

        // R1: brownout from active
        hold_bit = 1; tick();
        chk_state("R1 pre brownout", S_ACT);
        supply_ok = 0; tick();
        chk_state("R1 brownout", S_NOSUP);
        supply_ok = 1; tick();
        chk_state("R2 re-config", S_CFG);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule